// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter

This block turns one parallel word into an asynchronous serial frame on a single output line. A frame opens with a low start bit, carries 5, 7 or 8 data bits beginning with bit 0, may add a parity bit that the block computes itself, and closes with a high stop period of one, one and a half or two bit times. Between frames the line rests high.

Words enter through a valid/ready handshake. The word, its length, its parity mode and its stop length are all captured in the cycle the word is accepted. Later changes on those inputs have no effect on the frame already in progress. Timing comes from an external enable, `tick16`, which pulses sixteen times per bit time. Because of this oversampled tick the block can make a stop period of one and a half bits. The block does not make the tick itself.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx_line` is 1 and `in_ready` is 1.
- R2: A word is accepted on a rising clock edge where `in_valid` and `in_ready` are both 1. From the cycle after that edge, `tx_line` is 0 for exactly 16 `tick16` pulses. Any tick in the accept cycle itself is not counted.
- R3: The data bits follow the start bit with bit 0 first. Each data bit lasts 16 ticks.
- R4: `cfg_len` selects how many bits are sent: 0 sends 5, 1 sends 7, and 2 or 3 sends 8. Word bits above the selected length are ignored, both in the frame and in the parity.
- R5: `cfg_par` selects the parity mode: 1 is even, 2 is odd, and 0 or 3 is none. For even parity, the parity bit is the XOR of the sent data bits. For odd parity, it is the inverse of that XOR. The parity bit lasts 16 ticks and follows the last data bit.
- R6: When parity is off, the stop period starts right after the last data bit. No parity time is inserted.
- R7: `cfg_stop` selects the length of the high stop period: 0 gives 16 ticks, 1 gives 24 ticks, and 2 or 3 gives 32 ticks.
- R8: `in_ready` is 0 from the cycle after acceptance up to the last stop tick. It returns to 1 on the cycle after that tick, so a held `in_valid` starts the next frame with no idle gap.
- R9: Changes to `in_data`, `cfg_len`, `cfg_par` or `cfg_stop` while a frame is in progress do not change that frame.
- R10: During a frame, `tx_line` changes only in a cycle that follows a `tick16` pulse. With no ticks, the frame stalls with the line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Enable pulse, sixteen per bit time |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Block can accept a word |
| in_data | input | DATA_W | Word to send |
| cfg_len | input | 2 | Data length code |
| cfg_par | input | 2 | Parity mode code |
| cfg_stop | input | 2 | Stop length code |
| tx_line | output | 1 | Serial output, high when idle |

## Verification
The bench targets the following corner cases:
- **Stop length of 24 ticks.** A design that rounds it to a whole bit makes the line go high for too long or too short, and `in_ready` comes back on the wrong cycle.
- **Parity turned off.** A design that leaves a spare 16-tick slot when parity is off stretches the frame by one bit.
- **Short word with high bits set.** A design that counts those bits leaks them into the parity.
- **Inputs scrambled right after acceptance.** A design that reads the live inputs sends the wrong bits, parity or stop length.
- **Irregular tick patterns and a word held valid back-to-back.** These expose a design that counts clock cycles instead of ticks, or one that adds an idle cycle between frames.

// File: rtl/sft_pkg.sv
package sft_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } sft_state_e;

  localparam logic [1:0] LEN_5   = 2'd0;
  localparam logic [1:0] LEN_7   = 2'd1;
  localparam logic [1:0] PAR_EVN = 2'd1;
  localparam logic [1:0] PAR_ODD = 2'd2;
  localparam logic [1:0] STP_1   = 2'd0;
  localparam logic [1:0] STP_1H  = 2'd1;

endpackage

// File: rtl/sft_cfg_decode.sv
module sft_cfg_decode #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int CNT_W = $clog2(2 * OSR + 1)
) (
  input  logic [1:0]       len_code,
  input  logic [1:0]       par_code,
  input  logic [1:0]       stop_code,
  output logic [IDX_W-1:0] last_idx,
  output logic             par_en,
  output logic             par_odd,
  output logic [CNT_W-1:0] stop_ticks
);
  import sft_pkg::*;

  always_comb begin
    case (len_code)
      LEN_5:   last_idx = IDX_W'(4);
      LEN_7:   last_idx = IDX_W'(6);
      default: last_idx = IDX_W'(DATA_W - 1);
    endcase
  end

  always_comb begin
    par_en  = (par_code == PAR_EVN) || (par_code == PAR_ODD);
    par_odd = (par_code == PAR_ODD);
  end

  always_comb begin
    case (stop_code)
      STP_1:   stop_ticks = CNT_W'(OSR);
      STP_1H:  stop_ticks = CNT_W'(OSR + OSR / 2);
      default: stop_ticks = CNT_W'(2 * OSR);
    endcase
  end

  // R7: every stop period lasts at least one full bit
  always_comb begin
    a_r7_stop_min: assert (stop_ticks >= CNT_W'(OSR))
      else $error("stop length below one bit");
  end

endmodule

// File: rtl/sft_parity.sv
module sft_parity #(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] word,
  input  logic [IDX_W-1:0]  last_idx,
  input  logic              odd,
  output logic              par_bit
);
  logic [DATA_W-1:0] masked;

  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign masked[g] = word[g] & (IDX_W'(g) <= last_idx);
  end

  assign par_bit = (^masked) ^ odd;

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int CNT_W = $clog2(2 * OSR + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [1:0]        cfg_len,
  input  logic [1:0]        cfg_par,
  input  logic [1:0]        cfg_stop,
  output logic              tx_line
);
  import sft_pkg::*;

  sft_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] sh;
  logic              par_q;
  logic              pen_q;
  logic [IDX_W-1:0]  last_q;
  logic [CNT_W-1:0]  stop_q;

  logic [IDX_W-1:0]  dec_last;
  logic              dec_pen;
  logic              dec_odd;
  logic [CNT_W-1:0]  dec_stop;
  logic              dec_par;

  logic              accept;
  logic              busy_tick;
  logic [CNT_W-1:0]  limit;
  logic              slot_end;

  sft_cfg_decode #(.DATA_W(DATA_W), .OSR(OSR)) u_dec (
    .len_code  (cfg_len),
    .par_code  (cfg_par),
    .stop_code (cfg_stop),
    .last_idx  (dec_last),
    .par_en    (dec_pen),
    .par_odd   (dec_odd),
    .stop_ticks(dec_stop)
  );

  sft_parity #(.DATA_W(DATA_W)) u_par (
    .word    (in_data),
    .last_idx(dec_last),
    .odd     (dec_odd),
    .par_bit (dec_par)
  );

  assign accept    = in_valid && in_ready;
  assign busy_tick = tick16 && (state != ST_IDLE);
  assign limit     = (state == ST_STOP) ? stop_q : CNT_W'(OSR);
  assign slot_end  = (cnt == limit - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      tx_line  <= 1'b1;
      in_ready <= 1'b1;
      cnt      <= '0;
      idx      <= '0;
      sh       <= '0;
      par_q    <= 1'b0;
      pen_q    <= 1'b0;
      last_q   <= '0;
      stop_q   <= CNT_W'(OSR);
    end else if (state == ST_IDLE) begin
      if (accept) begin
        sh       <= in_data;
        last_q   <= dec_last;
        pen_q    <= dec_pen;
        stop_q   <= dec_stop;
        par_q    <= dec_par;
        cnt      <= '0;
        idx      <= '0;
        state    <= ST_START;
        tx_line  <= 1'b0;
        in_ready <= 1'b0;
      end
    end else if (busy_tick) begin
      if (!slot_end) begin
        cnt <= cnt + CNT_W'(1);
      end else begin
        cnt <= '0;
        case (state)
          ST_START: begin
            state   <= ST_DATA;
            tx_line <= sh[0];
          end
          ST_DATA: begin
            if (idx == last_q) begin
              if (pen_q) begin
                state   <= ST_PAR;
                tx_line <= par_q;
              end else begin
                state   <= ST_STOP;
                tx_line <= 1'b1;
              end
            end else begin
              idx     <= idx + IDX_W'(1);
              sh      <= sh >> 1;
              tx_line <= sh[1];
            end
          end
          ST_PAR: begin
            state   <= ST_STOP;
            tx_line <= 1'b1;
          end
          default: begin
            state    <= ST_IDLE;
            tx_line  <= 1'b1;
            in_ready <= 1'b1;
          end
        endcase
      end
    end
  end

  a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> tx_line);

  a_r2_accept_start: assert property (@(posedge clk) disable iff (rst)
    accept |=> (!tx_line && !in_ready));

  a_r10_line_on_tick: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && !tick16) |=> $stable(tx_line));

  a_r8_release_from_stop: assert property (@(posedge clk) disable iff (rst)
    $rose(in_ready) |-> (tx_line && $past(state == ST_STOP)));

  a_r9_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && $past(!in_ready)) |-> ($stable(stop_q) && $stable(pen_q) && $stable(last_q)));

  a_r6_parity_only_when_on: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PAR) |-> pen_q);

endmodule

// File: tb/serial_frame_tx_tb.sv
module serial_frame_tx_tb;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick16 = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [DATA_W-1:0] in_data = '0;
  logic [1:0] cfg_len = 2'd0;
  logic [1:0] cfg_par = 2'd0;
  logic [1:0] cfg_stop = 2'd0;
  logic tx_line;

  always #2 clk = ~clk;

  serial_frame_tx #(.DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst), .tick16(tick16), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .cfg_len(cfg_len),
    .cfg_par(cfg_par), .cfg_stop(cfg_stop), .tx_line(tx_line)
  );

  int tests = 0;
  int fails = 0;
  int cycn = 0;
  int tick_mode = 0;
  string cur_req = "R1";

  // reference model
  bit exp_ready = 1'b1;
  bit exp_line  = 1'b1;
  bit accepted  = 1'b0;
  bit levels[$];

  task automatic check(string req, logic act, bit exp, string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b (cycle %0d)", req, what, act, exp, cycn);
    end
  endtask

  function automatic void build_frame();
    int n;
    int stl;
    bit p;
    n = (cfg_len == 2'd0) ? 5 : (cfg_len == 2'd1) ? 7 : 8;
    stl = (cfg_stop == 2'd0) ? 16 : (cfg_stop == 2'd1) ? 24 : 32;
    levels.delete();
    for (int i = 0; i < 16; i++) levels.push_back(1'b0);
    p = 1'b0;
    for (int b = 0; b < n; b++) begin
      p ^= in_data[b];
      for (int i = 0; i < 16; i++) levels.push_back(in_data[b]);
    end
    if (cfg_par == 2'd1 || cfg_par == 2'd2) begin
      if (cfg_par == 2'd2) p = ~p;
      for (int i = 0; i < 16; i++) levels.push_back(p);
    end
    for (int i = 0; i < stl; i++) levels.push_back(1'b1);
  endfunction

  task automatic cyc();
    case (tick_mode)
      0: tick16 = 1'b1;
      1: tick16 = (cycn % 3 == 0);
      default: tick16 = ((cycn % 5) != 1) && ((cycn % 7) != 3);
    endcase
    accepted = 1'b0;
    if (in_valid && exp_ready) begin
      build_frame();
      exp_line  = 1'b0;
      exp_ready = 1'b0;
      accepted  = 1'b1;
    end else if (!exp_ready && tick16) begin
      void'(levels.pop_front());
      if (levels.size() == 0) begin
        exp_ready = 1'b1;
        exp_line  = 1'b1;
      end else begin
        exp_line = levels[0];
      end
    end
    @(posedge clk);
    #1;
    cycn++;
    check(cur_req, tx_line, exp_line, "tx_line");
    check("R8", in_ready, exp_ready, "in_ready");
  endtask

  task automatic send(input logic [7:0] d, input logic [1:0] l, input logic [1:0] p,
                      input logic [1:0] s, input bit scramble, input string req);
    cur_req  = req;
    in_data  = d;
    cfg_len  = l;
    cfg_par  = p;
    cfg_stop = s;
    in_valid = 1'b1;
    do cyc(); while (!accepted);
    in_valid = 1'b0;
    if (scramble) begin
      in_data  = ~d;
      cfg_len  = l + 2'd1;
      cfg_par  = p + 2'd1;
      cfg_stop = s + 2'd2;
    end
    do cyc(); while (!exp_ready);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    rst = 1'b0;
    check("R1", tx_line, 1'b1, "reset line");
    check("R1", in_ready, 1'b1, "reset ready");
    repeat (3) cyc();

    tick_mode = 0;
    send(8'hA5, 2'd2, 2'd0, 2'd0, 1'b0, "R3");
    send(8'hFF, 2'd0, 2'd1, 2'd0, 1'b0, "R4");   // 5 bits, even parity over 5 ones
    send(8'h6C, 2'd1, 2'd2, 2'd2, 1'b0, "R5");   // 7 bits, odd, 2 stop
    send(8'h3B, 2'd3, 2'd1, 2'd1, 1'b0, "R7");   // 8 bits, even, 1.5 stop
    send(8'h81, 2'd2, 2'd3, 2'd1, 1'b0, "R6");   // parity code 3 -> none
    tick_mode = 1;
    send(8'h5A, 2'd2, 2'd2, 2'd3, 1'b1, "R9");
    send(8'hE0, 2'd0, 2'd2, 2'd1, 1'b1, "R9");
    tick_mode = 2;
    send(8'hC3, 2'd1, 2'd1, 2'd0, 1'b0, "R10");
    send(8'h01, 2'd2, 2'd0, 2'd1, 1'b0, "R2");
    // held-valid back-to-back frames
    tick_mode = 0;
    send(8'h96, 2'd2, 2'd1, 2'd1, 1'b0, "R8");
    send(8'h69, 2'd2, 2'd2, 2'd0, 1'b0, "R8");
    // stall: no ticks mid-frame, line must hold
    cur_req  = "R10";
    in_data  = 8'h0F; cfg_len = 2'd2; cfg_par = 2'd0; cfg_stop = 2'd0;
    in_valid = 1'b1;
    do cyc(); while (!accepted);
    in_valid = 1'b0;
    repeat (20) cyc();
    tick_mode = 3;
    begin
      int saved;
      saved = cycn;
      // mode 3 falls into pattern; force quiet stretch by holding tick low directly
      for (int i = 0; i < 10; i++) begin
        tick16 = 1'b0;
        @(posedge clk); #1; cycn++;
        check("R10", tx_line, exp_line, "stalled line");
        check("R8", in_ready, 1'b0, "stalled ready");
      end
      if (cycn != saved + 10) fails++;
    end
    tick_mode = 0;
    do cyc(); while (!exp_ready);
    repeat (3) cyc();
    check("R1", tx_line, 1'b1, "final idle");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule